// File: doc/BRIEF.md
# Posted Column Command Latency Line

This block sits between a memory controller's command scheduler and the internal core side of a DRAM device model. A read or write may be issued on the clock right after the row activate that opens its bank. The block holds such a posted column command for a programmable number of clocks, the additive latency, and then presents it to the core with its bank and column.

The latency setting is a level input sampled on every clock edge. It is adopted only while no posted command is still waiting to issue, so a change made while the line is busy never re-times a command already in flight. A small control state machine tracks this. In `LAT_OPEN` no command waits and the setting is adopted. The `POST` transition moves it from `LAT_OPEN` to `LAT_LOCKED` when a command is posted that will issue two or more clocks later. `LAT_LOCKED` holds and re-arms on every further post. The `DRAIN` transition returns it to `LAT_OPEN` on the clock before the last waiting command issues.

For every bank the block also counts the clocks since that bank was last activated. It checks each posted command against a parameterised activate-to-column minimum, using the clock in which the command reaches the core, and raises a flag for one clock when the latency falls short.

Top module: `posted_cmd_delay`

## Requirements
- R1: While reset is asserted and in the first clock after it, `icmd_o` is NOP (00), `ibank_o` and `icol_o` are zero, `rcd_viol_o` is low, and the held latency is 0.
- R2: The command encoding on `cmd_i` and `icmd_o` is 00 NOP, 01 activate, 10 read, 11 write. Reads and writes are passed to `icmd_o`. An activate never appears on `icmd_o`.
- R3: With a held latency of 0, a read or write is driven on `icmd_o`, `ibank_o` and `icol_o` in the same clock in which it is on the inputs, with no register in the path.
- R4: With a held latency of n (1 to 4), a read or write posted in clock t appears on the outputs in clock t+n, with its own bank and column.
- R5: In every clock in which `icmd_o` is NOP, `ibank_o` and `icol_o` are zero.
- R6: `al_i` is sampled at every clock edge. A value above 4 is taken as 4.
- R7: A sampled `al_i` is ignored when some already-posted command, including one posted in that same clock, would issue after the current clock. In that case the held latency stays unchanged.
- R8: A read or write posted in clock t to a bank last activated in clock a is a violation when t + latency − a < TRCD (default 3). A bank that has never been activated gives no violation.
- R9: For each violating command, `rcd_viol_o` is high in clock t+1 only. It is low after any non-violating command, and each bank's activate history is independent of the other banks.
- R10: A violating command is still delivered to the core with its normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Posted command: 00 NOP, 01 activate, 10 read, 11 write |
| bank_i | input | BANK_W (3) | Bank of the posted command |
| col_i | input | COL_W (10) | Column of the posted command (ignored for activate) |
| al_i | input | AL_W (3) | Requested additive latency in clocks |
| icmd_o | output | 2 | Command presented to the core side |
| ibank_o | output | BANK_W (3) | Bank of the core-side command |
| icol_o | output | COL_W (10) | Column of the core-side command |
| rcd_viol_o | output | 1 | One-clock flag for an activate-to-column shortfall |

## Verification
The assertions check the following on every clock:
- the zero-latency pass-through;
- the one-clock delay whenever the latency has been held at 1;
- zeroed address fields alongside a NOP;
- that the held latency never moves while the control machine is locked or a command is being posted;
- that a violation flag only ever follows a posted read or write.

Exact issue timing at latencies 2 to 4 is shown only by the bench's reference model, comparing every clock. So are the clamping of oversized settings, the rejection and later adoption of latency changes around busy periods, and the arithmetic of the per-bank activate check across interleaved banks.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_ACT = 2'b01,
        CMD_RD  = 2'b10,
        CMD_WR  = 2'b11
    } cmd_e;

    typedef enum logic {
        LAT_OPEN   = 1'b0,
        LAT_LOCKED = 1'b1
    } lat_state_e;

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/pcd_lat_ctrl.sv
module pcd_lat_ctrl
    import pcd_pkg::*;
#(
    parameter int AL_MAX = 4,
    parameter int AL_W   = $clog2(AL_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_i,
    input  logic [AL_W-1:0] al_req_i,
    output logic [AL_W-1:0] al_q
);

    lat_state_e      state_q, state_d;
    logic [AL_W-1:0] remain_q, remain_d;
    logic [AL_W-1:0] al_clamped;
    logic            adopt;

    assign al_clamped = (int'(al_req_i) > AL_MAX) ? AL_W'(AL_MAX) : al_req_i;

    // next state: POST into LOCKED, DRAIN back to OPEN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAT_OPEN:   if (post_i && (al_q > AL_W'(1)))    state_d = LAT_LOCKED;
            LAT_LOCKED: if (!post_i && (remain_q == AL_W'(1))) state_d = LAT_OPEN;
            default:    state_d = LAT_OPEN;
        endcase
    end

    // outputs of the machine: remaining wait and adoption enable
    always_comb begin
        adopt    = (state_q == LAT_OPEN) && !post_i;
        remain_d = post_i ? (al_q - AL_W'(1))
                          : ((remain_q != '0) ? (remain_q - AL_W'(1)) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LAT_OPEN;
            remain_q <= '0;
            al_q     <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            if (adopt) al_q <= al_clamped;
        end
    end

    // R7: a held latency may not move while commands wait
    a_r7_lat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LAT_LOCKED || post_i) |=> $stable(al_q));

endmodule

// File: rtl/pcd_shift_line.sv
module pcd_shift_line
    import pcd_pkg::*;
#(
    parameter int AL_MAX = 4,
    parameter int AL_W   = $clog2(AL_MAX + 1),
    parameter int BANK_W = 3,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              in_cmd,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [COL_W-1:0]  in_col,
    input  logic [AL_W-1:0]   al_q,
    output cmd_e              out_cmd,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);

    cmd_e              g_cmd;
    logic [BANK_W-1:0] g_bank;
    logic [COL_W-1:0]  g_col;

    cmd_e              st_cmd  [AL_MAX];
    logic [BANK_W-1:0] st_bank [AL_MAX];
    logic [COL_W-1:0]  st_col  [AL_MAX];

    // only column commands enter the line; others become an all-zero slot
    always_comb begin
        if (is_column(in_cmd)) begin
            g_cmd  = in_cmd;
            g_bank = in_bank;
            g_col  = in_col;
        end else begin
            g_cmd  = CMD_NOP;
            g_bank = '0;
            g_col  = '0;
        end
    end

    for (genvar k = 0; k < AL_MAX; k++) begin : g_stage
        cmd_e              src_cmd;
        logic [BANK_W-1:0] src_bank;
        logic [COL_W-1:0]  src_col;
        if (k == 0) begin : g_head
            assign src_cmd  = g_cmd;
            assign src_bank = g_bank;
            assign src_col  = g_col;
        end else begin : g_body
            assign src_cmd  = st_cmd[k-1];
            assign src_bank = st_bank[k-1];
            assign src_col  = st_col[k-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_cmd[k]  <= CMD_NOP;
                st_bank[k] <= '0;
                st_col[k]  <= '0;
            end else if (al_q > AL_W'(k)) begin
                st_cmd[k]  <= src_cmd;
                st_bank[k] <= src_bank;
                st_col[k]  <= src_col;
            end else begin
                st_cmd[k]  <= CMD_NOP;
                st_bank[k] <= '0;
                st_col[k]  <= '0;
            end
        end
    end

    // tap select: latency 0 is the gated input, n picks stage n-1
    always_comb begin
        out_cmd  = g_cmd;
        out_bank = g_bank;
        out_col  = g_col;
        for (int k = 0; k < AL_MAX; k++) begin
            if (al_q == AL_W'(k + 1)) begin
                out_cmd  = st_cmd[k];
                out_bank = st_bank[k];
                out_col  = st_col[k];
            end
        end
    end

    // R5: an empty tap carries no address
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd == CMD_NOP) |-> (out_bank == '0 && out_col == '0));

endmodule

// File: rtl/pcd_rcd_track.sv
module pcd_rcd_track
    import pcd_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = $clog2(NBANK),
    parameter int TRCD   = 3,
    parameter int AL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [AL_W-1:0]   al_q,
    output logic              viol_q
);

    localparam int CW = $clog2(TRCD + 1);

    logic [CW-1:0] since_act [NBANK];
    logic          short_gap;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                since_act[b] <= CW'(TRCD);
            else if (cmd_i == CMD_ACT && bank_i == BANK_W'(b))
                since_act[b] <= CW'(1);
            else if (since_act[b] < CW'(TRCD))
                since_act[b] <= since_act[b] + CW'(1);
        end
    end

    assign short_gap = (int'(since_act[bank_i]) + int'(al_q)) < TRCD;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= is_column(cmd_i) && short_gap;
    end

    // R9: a flag only ever follows a posted read or write
    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |-> $past(is_column(cmd_i)));

endmodule

// File: rtl/posted_cmd_delay.sv
module posted_cmd_delay
    import pcd_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int BANK_W = $clog2(NBANK),
    parameter int COL_W  = 10,
    parameter int AL_MAX = 4,
    parameter int AL_W   = $clog2(AL_MAX + 1),
    parameter int TRCD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [AL_W-1:0]   al_i,
    output logic [1:0]        icmd_o,
    output logic [BANK_W-1:0] ibank_o,
    output logic [COL_W-1:0]  icol_o,
    output logic              rcd_viol_o
);

    cmd_e            cmd_in;
    cmd_e            cmd_out;
    logic [AL_W-1:0] al_q;
    logic            post;

    assign cmd_in = cmd_e'(cmd_i);
    assign post   = is_column(cmd_in) && (al_q != '0);
    assign icmd_o = cmd_out;

    pcd_lat_ctrl #(.AL_MAX(AL_MAX), .AL_W(AL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_i   (post),
        .al_req_i (al_i),
        .al_q     (al_q)
    );

    pcd_shift_line #(.AL_MAX(AL_MAX), .AL_W(AL_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_cmd   (cmd_in),
        .in_bank  (bank_i),
        .in_col   (col_i),
        .al_q     (al_q),
        .out_cmd  (cmd_out),
        .out_bank (ibank_o),
        .out_col  (icol_o)
    );

    pcd_rcd_track #(.NBANK(NBANK), .BANK_W(BANK_W), .TRCD(TRCD), .AL_W(AL_W)) u_rcd (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_in),
        .bank_i (bank_i),
        .al_q   (al_q),
        .viol_q (rcd_viol_o)
    );

    // R3: zero latency is a direct path
    a_r3_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q == '0 && is_column(cmd_in)) |-> (icmd_o == cmd_i && ibank_o == bank_i && icol_o == col_i));

    // R4: latency held at one delays by exactly one clock
    a_r4_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (al_q == AL_W'(1) && $past(al_q) == AL_W'(1) && $past(is_column(cmd_in)))
            |-> (icmd_o == $past(cmd_i) && icol_o == $past(col_i)));

endmodule

// File: tb/posted_cmd_delay_test.sv
module posted_cmd_delay_test;

    localparam int TRCD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic [2:0] bank_i = '0;
    logic [9:0] col_i = '0;
    logic [2:0] al_i = '0;
    logic [1:0] icmd_o;
    logic [2:0] ibank_o;
    logic [9:0] icol_o;
    logic       rcd_viol_o;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int cyc = 0;
    int al_cur = 0;
    int lastact [8];
    int q_cmd  [int];
    int q_bank [int];
    int q_col  [int];
    bit viol_exp = 1'b0;

    always #4 clk = ~clk;

    posted_cmd_delay uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bank_i(bank_i), .col_i(col_i),
        .al_i(al_i), .icmd_o(icmd_o), .ibank_o(ibank_o), .icol_o(icol_o),
        .rcd_viol_o(rcd_viol_o)
    );

    task automatic step(input int c, input int b, input int col);
        int  ec, eb, el;
        bit  colcmd, waiting, nv;
        string tag;
        @(negedge clk);
        cmd_i  = 2'(c);
        bank_i = 3'(b);
        col_i  = 10'(col);
        #3;
        colcmd = (c == 2) || (c == 3);
        ec = 0; eb = 0; el = 0;
        if (colcmd && al_cur == 0) begin
            ec = c; eb = b; el = col;          // R3 direct path
        end else if (q_cmd.exists(cyc)) begin
            ec = q_cmd[cyc]; eb = q_bank[cyc]; el = q_col[cyc];   // R4 delayed issue
        end
        tag = (ec == 0) ? "R5" : ((al_cur == 0) ? "R3" : "R4");
        checks++;
        if (int'(icmd_o) != ec || int'(ibank_o) != eb || int'(icol_o) != el) begin
            fails++;
            $display("FAIL %s/R2 cycle %0d al=%0d: actual cmd=%0d bank=%0d col=%0d expected cmd=%0d bank=%0d col=%0d",
                     tag, cyc, al_cur, icmd_o, ibank_o, icol_o, ec, eb, el);
        end
        checks++;
        if (rcd_viol_o != viol_exp) begin
            fails++;
            $display("FAIL R8/R9 cycle %0d: actual viol=%0d expected viol=%0d", cyc, rcd_viol_o, viol_exp);
        end
        // model the clock edge
        waiting = colcmd && (al_cur > 0);
        foreach (q_cmd[k]) if (k > cyc) waiting = 1'b1;
        nv = 1'b0;
        if (colcmd) begin
            if (cyc + al_cur - lastact[b] < TRCD) nv = 1'b1;
            if (al_cur > 0) begin
                q_cmd[cyc + al_cur]  = c;
                q_bank[cyc + al_cur] = b;
                q_col[cyc + al_cur]  = col;
            end
        end
        if (c == 1) lastact[b] = cyc;
        if (!waiting) al_cur = (int'(al_i) > 4) ? 4 : int'(al_i);   // R6, R7
        if (q_cmd.exists(cyc)) begin
            q_cmd.delete(cyc); q_bank.delete(cyc); q_col.delete(cyc);
        end
        viol_exp = nv;
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) lastact[i] = -1000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (icmd_o != 2'b00 || ibank_o != 0 || icol_o != 0 || rcd_viol_o != 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual cmd=%0d bank=%0d col=%0d viol=%0d expected all zero",
                     icmd_o, ibank_o, icol_o, rcd_viol_o);
        end
        rst_n = 1'b1;

        // R3, R8: latency 0, read right after activate is short; unopened bank is not
        al_i = 3'd0;
        step(1, 0, 0);
        step(2, 0, 5);
        step(3, 1, 9);
        step(1, 1, 0);
        idle(3);
        step(3, 1, 17);

        // R4, R8: latency 2 covers a one-clock gap with TRCD 3
        al_i = 3'd2;
        idle(2);
        step(1, 2, 0);
        step(2, 2, 7);
        step(0, 0, 0);
        step(3, 2, 8);
        idle(4);

        // R7: change while busy is ignored, reverted before drain
        al_i = 3'd4;
        idle(2);
        step(2, 3, 33);
        al_i = 3'd1;
        step(0, 0, 0);
        al_i = 3'd4;
        idle(5);
        // R7: adopted once drained
        al_i = 3'd1;
        idle(2);
        step(1, 4, 0);
        step(2, 4, 44);      // R8, R10: short at latency 1, still issued
        step(3, 4, 45);
        idle(3);

        // R6: oversized setting clamps to 4
        al_i = 3'd7;
        idle(2);
        step(1, 5, 0);
        step(3, 5, 55);
        step(2, 6, 66);
        idle(6);

        // R9: interleaved banks at latency 3, back-to-back commands
        al_i = 3'd3;
        idle(2);
        step(1, 6, 0);
        step(1, 7, 0);
        step(2, 6, 100);
        step(3, 7, 101);
        step(2, 0, 102);
        al_i = 3'd0;        // R7: requested mid-stream, waits for drain
        step(2, 6, 103);
        idle(6);
        step(2, 7, 104);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule